// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a small processor core. It keeps one accumulator and runs a fixed set of sixteen instructions. Program and data share one word-wide synchronous memory outside the core. The core drives a single address, raises a read strobe or a write strobe, and captures read data one cycle after the read strobe. Each instruction passes through three phases: fetch, decode, then execute. The core repeats this until it reaches a stop instruction, then parks and makes no further memory accesses. A handshaked input port feeds the input instruction, and an output port with a one-cycle strobe serves the output instruction.

Inside the core are a program counter, an instruction register, a memory address register, a memory data register, the accumulator and three comparison flags (greater, equal, less). Every memory access goes through the address register and the data register. The controller is one enumerated state machine with these states: ST_FETCH_ADDR (program counter to address register), ST_FETCH_REQ (read strobe), ST_FETCH_CAP (read word into data register), ST_FETCH_IR (data register into instruction register, program counter plus one), ST_DECODE, ST_OPND_REQ, ST_OPND_CAP, ST_EXECUTE, ST_WRITE, ST_IN_WAIT and ST_HALT.

The transitions are as follows. The four fetch states run in a chain into ST_DECODE. From ST_DECODE the controller goes to ST_HALT on the stop code, back to ST_FETCH_ADDR on any jump, to ST_IN_WAIT on input, and to ST_WRITE on store or clear. Every other instruction goes to ST_OPND_REQ. ST_OPND_REQ leads to ST_OPND_CAP and then to ST_EXECUTE. ST_EXECUTE goes to ST_WRITE for increment and decrement, and to ST_FETCH_ADDR otherwise. ST_WRITE always returns to ST_FETCH_ADDR. ST_IN_WAIT leaves for ST_WRITE when input is valid. ST_HALT never leaves before reset.

Top module: `acc_cpu`

## Requirements
- R1: After reset is released, the first memory read is at address 0. While reset is held, halted, mem_wr, in_ready and out_valid are all low.
- R2: An instruction word holds the opcode in bits 15:12 and the address field in bits 11:0. Instructions run from consecutive addresses unless a jump is taken.
- R3: LOAD (0000) copies memory[X] into the accumulator. STORE (0001) writes the accumulator to memory[X]. CLEAR (0010) writes zero to memory[X].
- R4: ADD (0011) sets the accumulator to accumulator plus memory[X], and SUBTRACT (0101) sets it to accumulator minus memory[X], both modulo 2^16.
- R5: INCREMENT (0100) writes memory[X]+1 back to memory[X], and DECREMENT (0110) writes memory[X]-1 back, both modulo 2^16.
- R6: COMPARE (0111) compares memory[X] and the accumulator as signed numbers. It sets exactly one of three flags: greater when memory[X] is larger, equal when they match, less when memory[X] is smaller. The jumps use these flags: JUMP (1000) always goes to X, and JUMPGT (1001), JUMPLT (1010), JUMPEQ (1011) and JUMPNEQ (1100) go to X only when greater, less, equal or not-equal holds.
- R7: IN (1101) raises in_ready and waits for in_valid. The word on in_data is written to memory[X] in the cycle right after the handshake.
- R8: OUT (1110) places memory[X] on out_data with out_valid high for exactly one cycle.
- R9: HALT (1111) sets halted, which stays high until reset. While halted, no memory read, memory write or output strobe occurs.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from memory |
| in_valid | input | 1 | Input word available |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | Core is waiting for an input word |
| out_valid | output | 1 | One-cycle strobe for out_data |
| out_data | output | 16 | Output word |
| halted | output | 1 | Stop instruction reached |

## Verification
Two events can fall in the same cycle. One is the input handshake completing. The other is the core entering its input-wait state, because in_valid may already be high before in_ready rises. The bench provokes this overlap by presenting the next input word after a random gap of zero to three cycles, so that a word often waits for the core. It judges the overlap by checking that exactly one word is consumed per input instruction, in order, with its value landing in the addressed cell. The bench compares memory contents and the output stream against an instruction-level model computed in the bench, over directed programs and seeded random programs that have forward jumps.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_CLEAR = 4'h2,
        OP_ADD   = 4'h3,
        OP_INC   = 4'h4,
        OP_SUB   = 4'h5,
        OP_DEC   = 4'h6,
        OP_CMP   = 4'h7,
        OP_JMP   = 4'h8,
        OP_JGT   = 4'h9,
        OP_JLT   = 4'hA,
        OP_JEQ   = 4'hB,
        OP_JNE   = 4'hC,
        OP_IN    = 4'hD,
        OP_OUT   = 4'hE,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_REQ,
        ST_FETCH_CAP,
        ST_FETCH_IR,
        ST_DECODE,
        ST_OPND_REQ,
        ST_OPND_CAP,
        ST_EXECUTE,
        ST_WRITE,
        ST_IN_WAIT,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } flags_t;

    localparam int OPC_W = 4;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e             op,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   opnd,
    output logic [DATA_W-1:0]   acc_next,
    output logic [DATA_W-1:0]   mem_next,
    output flags_t              cmp
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        case (op)
            OP_LOAD: acc_next = opnd;
            OP_ADD:  acc_next = acc + opnd;
            OP_SUB:  acc_next = acc - opnd;
            default: acc_next = acc;
        endcase
    end

    always_comb begin
        if (op == OP_DEC) mem_next = opnd - ONE;
        else              mem_next = opnd + ONE;
    end

    always_comb begin
        cmp.gt = $signed(opnd) >  $signed(acc);
        cmp.eq = opnd == acc;
        cmp.lt = $signed(opnd) <  $signed(acc);
    end

endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
    import acc_cpu_pkg::*;
(
    input  opcode_e op,
    input  flags_t  flg,
    output logic    take
);

    always_comb begin
        case (op)
            OP_JMP:  take = 1'b1;
            OP_JGT:  take = flg.gt;
            OP_JLT:  take = flg.lt;
            OP_JEQ:  take = flg.eq;
            OP_JNE:  take = !flg.eq;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    input  logic    in_valid,
    output state_e  state,
    output logic    mem_rd,
    output logic    mem_wr,
    output logic    in_ready,
    output logic    out_valid,
    output logic    halted
);

    state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH_ADDR;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        halted    = 1'b0;
        unique case (state)
            ST_FETCH_ADDR: nxt = ST_FETCH_REQ;
            ST_FETCH_REQ: begin
                mem_rd = 1'b1;
                nxt    = ST_FETCH_CAP;
            end
            ST_FETCH_CAP:  nxt = ST_FETCH_IR;
            ST_FETCH_IR:   nxt = ST_DECODE;
            ST_DECODE: begin
                case (op)
                    OP_HALT:                             nxt = ST_HALT;
                    OP_JMP, OP_JGT, OP_JLT, OP_JEQ, OP_JNE: nxt = ST_FETCH_ADDR;
                    OP_IN:                               nxt = ST_IN_WAIT;
                    OP_STORE, OP_CLEAR:                  nxt = ST_WRITE;
                    default:                             nxt = ST_OPND_REQ;
                endcase
            end
            ST_OPND_REQ: begin
                mem_rd = 1'b1;
                nxt    = ST_OPND_CAP;
            end
            ST_OPND_CAP:   nxt = ST_EXECUTE;
            ST_EXECUTE: begin
                out_valid = (op == OP_OUT);
                nxt = (op == OP_INC || op == OP_DEC) ? ST_WRITE : ST_FETCH_ADDR;
            end
            ST_WRITE: begin
                mem_wr = 1'b1;
                nxt    = ST_FETCH_ADDR;
            end
            ST_IN_WAIT: begin
                in_ready = 1'b1;
                if (in_valid) nxt = ST_WRITE;
            end
            ST_HALT:       halted = 1'b1;
            default:       nxt = ST_FETCH_ADDR;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    flags_t            flg_q;

    opcode_e           op;
    state_e            state;
    logic [DATA_W-1:0] acc_next;
    logic [DATA_W-1:0] mem_next;
    flags_t            cmp;
    logic              take;
    logic [ADDR_W-1:0] field;

    assign op    = opcode_e'(ir_q[DATA_W-1:ADDR_W]);
    assign field = ir_q[ADDR_W-1:0];

    acc_cpu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .in_valid  (in_valid),
        .state     (state),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .halted    (halted)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op),
        .acc      (acc_q),
        .opnd     (mdr_q),
        .acc_next (acc_next),
        .mem_next (mem_next),
        .cmp      (cmp)
    );

    acc_cpu_branch u_branch (
        .op   (op),
        .flg  (flg_q),
        .take (take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            flg_q <= '0;
        end else begin
            case (state)
                ST_FETCH_ADDR: mar_q <= pc_q;
                ST_FETCH_CAP:  mdr_q <= mem_rdata;
                ST_FETCH_IR: begin
                    ir_q <= mdr_q;
                    pc_q <= pc_q + PC_STEP;
                end
                ST_DECODE: begin
                    mar_q <= field;
                    if (take)            pc_q  <= field;
                    if (op == OP_STORE)  mdr_q <= acc_q;
                    if (op == OP_CLEAR)  mdr_q <= '0;
                end
                ST_OPND_CAP:   mdr_q <= mem_rdata;
                ST_EXECUTE: begin
                    acc_q <= acc_next;
                    if (op == OP_CMP)                  flg_q <= cmp;
                    if (op == OP_INC || op == OP_DEC)  mdr_q <= mem_next;
                end
                ST_IN_WAIT: if (in_valid) mdr_q <= in_data;
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign out_data  = mdr_q;

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic              halted
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                          // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);                                            // R9

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !out_valid));                // R9

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                     // R8

    AST_IN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (mem_wr && mem_wdata == $past(in_data))); // R7

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);                         // R7

endmodule

bind acc_cpu acc_cpu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .halted    (halted)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

    localparam int AW    = 12;
    localparam int DW    = 16;
    localparam int MEMN  = 256;
    localparam int DBASE = 128;
    localparam int DCNT  = 16;
    localparam int INQ   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid, halted;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk (clk), .rst_n (rst_n),
        .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
        .out_valid (out_valid), .out_data (out_data), .halted (halted)
    );

    logic [DW-1:0] img     [MEMN];
    logic [DW-1:0] mem     [MEMN];
    logic [DW-1:0] ref_mem [MEMN];
    logic [DW-1:0] in_q    [INQ];
    logic [DW-1:0] exp_out [64];
    logic [DW-1:0] dut_out [64];
    int exp_n;
    logic load_now = 1'b0;
    logic clr_mon  = 1'b1;

    int total = 0;
    int bad   = 0;

    // memory model: synchronous read, one-cycle latency
    always @(posedge clk) begin
        if (load_now) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= img[i];
        end else begin
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // monitor, sampled at the falling edge
    int dut_n, out_long, both_cnt, halt_act;
    logic prev_ov, seen_rd;
    logic [AW-1:0] first_addr;
    always @(negedge clk) begin
        if (clr_mon) begin
            dut_n = 0; out_long = 0; both_cnt = 0; halt_act = 0;
            prev_ov = 1'b0; seen_rd = 1'b0; first_addr = '1;
        end else begin
            if (out_valid) begin
                if (dut_n < 64) dut_out[dut_n] = out_data;
                dut_n++;
                if (prev_ov) out_long++;
            end
            prev_ov = out_valid;
            if (mem_rd && mem_wr) both_cnt++;
            if (halted && (mem_rd || mem_wr || out_valid)) halt_act++;
            if (mem_rd && !seen_rd) begin
                seen_rd = 1'b1;
                first_addr = mem_addr;
            end
        end
    end

    // input driver: word may be offered before in_ready rises
    int in_idx, gap;
    logic rdy_seen;
    always @(negedge clk) begin
        if (clr_mon) begin
            in_valid = 1'b0; in_idx = 0; rdy_seen = 1'b0;
            gap = $urandom_range(0, 3);
        end else begin
            if (in_valid && rdy_seen) begin
                in_valid = 1'b0;
                in_idx++;
                gap = $urandom_range(0, 3);
            end
            if (!in_valid) begin
                if (gap > 0) gap--;
                else if (in_idx < INQ) begin
                    in_valid = 1'b1;
                    in_data  = in_q[in_idx];
                end
            end
            rdy_seen = in_ready;
        end
    end

    function automatic logic [DW-1:0] ins(int op, int a);
        return {op[3:0], a[11:0]};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // instruction-level model from the requirements
    task automatic ref_run();
        logic [AW-1:0] pc = '0;
        logic [DW-1:0] r = '0, w, x;
        logic [AW-1:0] a;
        logic gt = 0, eq = 0, lt = 0;
        int ii = 0;
        bit done = 0;
        for (int i = 0; i < MEMN; i++) ref_mem[i] = img[i];
        exp_n = 0;
        for (int step = 0; step < 4000 && !done; step++) begin
            w  = ref_mem[pc[7:0]];
            pc = pc + 1'b1;
            a  = w[11:0];
            x  = ref_mem[a[7:0]];
            case (w[15:12])
                4'h0: r = x;
                4'h1: ref_mem[a[7:0]] = r;
                4'h2: ref_mem[a[7:0]] = '0;
                4'h3: r = r + x;
                4'h4: ref_mem[a[7:0]] = x + 1'b1;
                4'h5: r = r - x;
                4'h6: ref_mem[a[7:0]] = x - 1'b1;
                4'h7: begin
                    gt = $signed(x) > $signed(r);
                    eq = x == r;
                    lt = $signed(x) < $signed(r);
                end
                4'h8: pc = a;
                4'h9: if (gt) pc = a;
                4'hA: if (lt) pc = a;
                4'hB: if (eq) pc = a;
                4'hC: if (!eq) pc = a;
                4'hD: begin ref_mem[a[7:0]] = in_q[ii]; ii++; end
                4'hE: begin if (exp_n < 64) exp_out[exp_n] = x; exp_n++; end
                default: done = 1;
            endcase
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < MEMN; i++) img[i] = '0;
        for (int i = 0; i < INQ; i++) in_q[i] = DW'($urandom);
    endtask

    task automatic run_prog(string tag);
        int cyc = 0;
        ref_run();
        @(negedge clk);
        rst_n = 1'b0; load_now = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(!halted && !mem_wr && !in_ready && !out_valid, "R1", "reset outputs",
              {halted, mem_wr, in_ready, out_valid}, 0);
        load_now = 1'b0; clr_mon = 1'b0; rst_n = 1'b1;
        while (!halted && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check(halted, tag, "reached halt", int'(halted), 1);
        repeat (20) @(negedge clk);
        check(halted, "R9", "halted stays high", int'(halted), 1);
        check(halt_act == 0, "R9", "activity after halt", halt_act, 0);
        check(first_addr == '0, "R1", "first fetch address", int'(first_addr), 0);
        check(both_cnt == 0, "R10", "read and write together", both_cnt, 0);
        check(out_long == 0, "R8", "output strobe width", out_long, 0);
        check(dut_n == exp_n, tag, "output count", dut_n, exp_n);
        for (int i = 0; i < exp_n && i < dut_n && i < 64; i++)
            check(dut_out[i] == exp_out[i], tag, "output word", int'(dut_out[i]), int'(exp_out[i]));
        for (int i = DBASE; i < DBASE + DCNT; i++)
            check(mem[i] == ref_mem[i], tag, "data cell", int'(mem[i]), int'(ref_mem[i]));
    endtask

    task automatic random_prog();
        int len = $urandom_range(8, 30);
        clear_img();
        for (int p = 0; p < len; p++) begin
            int op = $urandom_range(0, 14);
            int a  = DBASE + $urandom_range(0, DCNT - 1);
            if (op >= 8 && op <= 12) begin
                a = p + 1 + $urandom_range(0, 3);
                if (a > len) a = len;
            end
            img[p] = ins(op, a);
        end
        img[len] = ins(15, 0);
        for (int i = DBASE; i < DBASE + DCNT; i++) begin
            case ($urandom_range(0, 3))
                0: img[i] = DW'($urandom_range(0, 3));
                1: img[i] = 16'h7FFF;
                2: img[i] = 16'hFFFF;
                default: img[i] = DW'($urandom);
            endcase
        end
        run_prog("R2");
    endtask

    task automatic main_seq();
        // R3: load, store, clear
        clear_img();
        img[0] = ins(0, 128); img[1] = ins(1, 129); img[2] = ins(2, 130);
        img[3] = ins(14, 129); img[4] = ins(15, 0);
        img[128] = 16'h1234; img[130] = 16'hBEEF;
        run_prog("R3");
        // R4: add and subtract wrap
        clear_img();
        img[0] = ins(0, 128); img[1] = ins(3, 129); img[2] = ins(1, 131);
        img[3] = ins(0, 130); img[4] = ins(5, 129); img[5] = ins(1, 132);
        img[6] = ins(15, 0);
        img[128] = 16'h7FFF; img[129] = 16'h0001; img[130] = 16'h0000;
        run_prog("R4");
        // R5: increment and decrement wrap
        clear_img();
        img[0] = ins(4, 128); img[1] = ins(6, 129); img[2] = ins(4, 130);
        img[3] = ins(6, 131); img[4] = ins(15, 0);
        img[128] = 16'hFFFF; img[129] = 16'h0000; img[130] = 16'h7FFF; img[131] = 16'h8000;
        run_prog("R5");
        // R6: compare flags and every jump kind
        clear_img();
        img[0]  = ins(0, 128);  img[1]  = ins(7, 129);  img[2]  = ins(9, 4);
        img[3]  = ins(2, 140);  img[4]  = ins(10, 6);   img[5]  = ins(2, 141);
        img[6]  = ins(11, 8);   img[7]  = ins(2, 142);  img[8]  = ins(12, 10);
        img[9]  = ins(2, 143);  img[10] = ins(7, 128);  img[11] = ins(11, 13);
        img[12] = ins(2, 138);  img[13] = ins(12, 15);  img[14] = ins(2, 139);
        img[15] = ins(7, 130);  img[16] = ins(10, 18);  img[17] = ins(2, 137);
        img[18] = ins(8, 20);   img[19] = ins(2, 136);  img[20] = ins(15, 0);
        img[128] = 16'd5; img[129] = 16'd7; img[130] = 16'hFFFD;
        for (int i = 136; i < 144; i++) img[i] = DW'(16'h00A0 + i);
        run_prog("R6");
        // R7: input handshake, values echoed out
        clear_img();
        img[0] = ins(13, 128); img[1] = ins(13, 129); img[2] = ins(14, 128);
        img[3] = ins(14, 129); img[4] = ins(13, 130); img[5] = ins(15, 0);
        run_prog("R7");
        // R8: back-to-back output instructions
        clear_img();
        img[0] = ins(14, 130); img[1] = ins(14, 131); img[2] = ins(14, 130);
        img[3] = ins(15, 0);
        img[130] = 16'hA5A5; img[131] = 16'h5A5A;
        run_prog("R8");
        // R2: random programs with forward jumps
        for (int n = 0; n < 40; n++) random_prog();
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        fork
            main_seq();
            begin
                repeat (190000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=expired expected=finished");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule